// File: doc/BRIEF.md
# Aliased Control and Status Register File

This block holds the control and status registers of a 64-bit hart. A single 12-bit address port with read and write strobes and a 64-bit data path serves every register. Reads are combinational and writes take effect on the rising clock edge. Several addresses have no storage of their own. The supervisor status, supervisor interrupt-enable and supervisor interrupt-pending addresses are masked windows onto the machine status register and the machine interrupt registers. The flag and rounding-mode addresses are windows onto the floating-point control byte.

Beside the access port, the block has three other functions. A time counter advances on every retired-instruction tick. Three dedicated inputs raise floating-point exception flags. A machine-return request updates the interrupt-enable bits of the status register and presents the saved return address as the resume PC. Any address without a dedicated meaning reads and writes an entry of a small generic bank. That entry is selected by the low address bits.

Top module: `csr_alias_file`

## Requirements
- R1: After reset, every register reads as zero: machine status, interrupt enable/pending, delegation, return PC, floating-point control, time and the generic bank.
- R2: `csr_rdata` shows the addressed register's current value in the same cycle while `csr_rd` is 1, and shows zero while `csr_rd` is 0.
- R3: Address 0x100 reads the machine status (0x300) ANDed with 0x80000003000DE162. A write to 0x100 replaces only the machine status bits selected by that mask. A write to 0x300 replaces all 64 bits.
- R4: Addresses 0x104 and 0x144 are views of 0x304 (enable) and 0x344 (pending) through mask 0x222, both on read and on write. Bits outside the mask keep their values on a write through a view.
- R5: A write to the delegation register 0x303 stores the data ANDed with 0x666.
- R6: The floating-point control byte at 0x003 is written from data bits 7:0 and reads back as its 8 bits zero-extended. Address 0x001 reads and writes control bits 4:0. Address 0x002 reads control bits 7:5 in result bits 2:0; a write to 0x002 puts data bits 2:0 into control bits 7:5 and leaves bits 4:0 unchanged.
- R7: The flag inputs `flag_nx`, `flag_dz` and `flag_nv` OR a 1 into control bits 0, 3 and 4 respectively. When a control, flag or rounding write falls in the same cycle, the write is applied first and the flag OR is applied on top.
- R8: The time register (0xC01) increments by one on each cycle with `insn_tick` high, wrapping from all-ones to zero. When a write to 0xC01 falls in the same cycle, the written value plus one is stored.
- R9: On a cycle with `mret_go` high, status bit 3 takes the previous value of bit 7, bit 7 becomes 1 and bit 17 becomes 0; all other bits are unchanged. This update applies on top of a same-cycle write to 0x300 or 0x100. `mret_pc` always equals the value stored at 0x341.
- R10: Any other address reads and writes a 64-bit entry of a bank with 2^GEN_AW entries (default 256), selected by the address bits GEN_AW-1:0. A write to an address listed in R3 to R9 never touches the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address |
| csr_rd | input | 1 | Read strobe; gates csr_rdata |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Combinational read data |
| insn_tick | input | 1 | One retired instruction; advances time |
| flag_nx | input | 1 | Raise inexact flag |
| flag_dz | input | 1 | Raise divide-by-zero flag |
| flag_nv | input | 1 | Raise invalid-operation flag |
| mret_go | input | 1 | Machine return: update status enable bits |
| mret_pc | output | 64 | Saved return address to resume at |

## Verification
Two pairs of functions can fall in the same cycle: an access-port write to the floating-point control byte together with a flag input, and a status write (full or through the supervisor window) together with a machine return. Both pairs are provoked by directed cycles that drive the two functions at once. They are also provoked by a long random stream in which writes, flag pulses, ticks and returns overlap freely. A behavioural model applies the port write first and the flag OR or return update after it, and every cycle it compares the read data and the resume PC against the design.

// File: rtl/csr_alias_pkg.sv
package csr_alias_pkg;

  localparam int XW = 64;
  localparam int AW = 12;
  localparam int FPW = 8;

  localparam logic [AW-1:0] ADR_FLAGS  = 12'h001;
  localparam logic [AW-1:0] ADR_RMODE  = 12'h002;
  localparam logic [AW-1:0] ADR_FPCTL  = 12'h003;
  localparam logic [AW-1:0] ADR_SSTAT  = 12'h100;
  localparam logic [AW-1:0] ADR_SIEN   = 12'h104;
  localparam logic [AW-1:0] ADR_SPEND  = 12'h144;
  localparam logic [AW-1:0] ADR_MSTAT  = 12'h300;
  localparam logic [AW-1:0] ADR_MDELEG = 12'h303;
  localparam logic [AW-1:0] ADR_MIEN   = 12'h304;
  localparam logic [AW-1:0] ADR_MRETPC = 12'h341;
  localparam logic [AW-1:0] ADR_MPEND  = 12'h344;
  localparam logic [AW-1:0] ADR_TIME   = 12'hC01;

  localparam logic [XW-1:0] SUP_STATUS_MASK = 64'h8000_0003_000D_E162;
  localparam logic [XW-1:0] SUP_INT_MASK    = 64'h0000_0000_0000_0222;
  localparam logic [XW-1:0] DELEG_MASK      = 64'h0000_0000_0000_0666;

  localparam int BIT_IE    = 3;
  localparam int BIT_PIE   = 7;
  localparam int BIT_MPRV  = 17;

  localparam int FLG_NX = 0;
  localparam int FLG_DZ = 3;
  localparam int FLG_NV = 4;
  localparam int FLG_W  = 5;
  localparam int RM_LO  = 5;
  localparam int RM_W   = 3;

  typedef enum logic [3:0] {
    SEL_FLAGS, SEL_RMODE, SEL_FPCTL, SEL_SSTAT, SEL_SIEN, SEL_SPEND,
    SEL_MSTAT, SEL_MDELEG, SEL_MIEN, SEL_MRETPC, SEL_MPEND, SEL_TIME,
    SEL_GEN
  } csr_sel_e;

  function automatic csr_sel_e decode_addr(input logic [AW-1:0] a);
    case (a)
      ADR_FLAGS:  return SEL_FLAGS;
      ADR_RMODE:  return SEL_RMODE;
      ADR_FPCTL:  return SEL_FPCTL;
      ADR_SSTAT:  return SEL_SSTAT;
      ADR_SIEN:   return SEL_SIEN;
      ADR_SPEND:  return SEL_SPEND;
      ADR_MSTAT:  return SEL_MSTAT;
      ADR_MDELEG: return SEL_MDELEG;
      ADR_MIEN:   return SEL_MIEN;
      ADR_MRETPC: return SEL_MRETPC;
      ADR_MPEND:  return SEL_MPEND;
      ADR_TIME:   return SEL_TIME;
      default:    return SEL_GEN;
    endcase
  endfunction

  // Replace only the bits selected by mask.
  function automatic logic [XW-1:0] merge_masked(input logic [XW-1:0] old_v,
                                                 input logic [XW-1:0] new_v,
                                                 input logic [XW-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  // Status update applied by a machine return.
  function automatic logic [XW-1:0] return_status(input logic [XW-1:0] st);
    logic [XW-1:0] r;
    r = st;
    r[BIT_IE]   = st[BIT_PIE];
    r[BIT_PIE]  = 1'b1;
    r[BIT_MPRV] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/csr_masked_reg.sv
module csr_masked_reg
  import csr_alias_pkg::*;
#(
  parameter logic [XW-1:0] STORE_MASK = '1,
  parameter logic [XW-1:0] VIEW_MASK  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_full,
  input  logic          wr_view,
  input  logic [XW-1:0] wr_data,
  output logic [XW-1:0] reg_q
);

  logic [XW-1:0] reg_d;

  always_comb begin
    reg_d = reg_q;
    if (wr_full) reg_d = wr_data;
    if (wr_view) reg_d = merge_masked(reg_d, wr_data, VIEW_MASK);
    reg_d = reg_d & STORE_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assert_full_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && !wr_view) |=> reg_q == ($past(wr_data) & STORE_MASK));

  assert_view_keeps_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_view && !wr_full) |=> (reg_q & ~VIEW_MASK) == ($past(reg_q) & ~VIEW_MASK));

endmodule

// File: rtl/csr_status_unit.sv
module csr_status_unit
  import csr_alias_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_full,
  input  logic          wr_view,
  input  logic [XW-1:0] wr_data,
  input  logic          mret,
  output logic [XW-1:0] status_q
);

  logic [XW-1:0] after_wr;
  logic [XW-1:0] status_d;

  always_comb begin
    after_wr = status_q;
    if (wr_full) after_wr = wr_data;
    if (wr_view) after_wr = merge_masked(after_wr, wr_data, SUP_STATUS_MASK);
    status_d = mret ? return_status(after_wr) : after_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assert_return_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !wr_full && !wr_view) |=>
      (status_q[BIT_IE] == $past(status_q[BIT_PIE])) && status_q[BIT_PIE] && !status_q[BIT_MPRV]);

  assert_sup_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_view && !wr_full && !mret) |=>
      (status_q & ~SUP_STATUS_MASK) == ($past(status_q) & ~SUP_STATUS_MASK));

endmodule

// File: rtl/csr_fp_unit.sv
module csr_fp_unit
  import csr_alias_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctl,
  input  logic           wr_flags,
  input  logic           wr_rm,
  input  logic [XW-1:0]  wr_data,
  input  logic           set_nx,
  input  logic           set_dz,
  input  logic           set_nv,
  output logic [FPW-1:0] fpctl_q
);

  logic [FPW-1:0] fp_after_wr;
  logic [FPW-1:0] fp_d;
  logic           any_flag_set;

  assign any_flag_set = set_nx | set_dz | set_nv;

  always_comb begin
    fp_after_wr = fpctl_q;
    if (wr_ctl)   fp_after_wr = wr_data[FPW-1:0];
    if (wr_flags) fp_after_wr[FLG_W-1:0] = wr_data[FLG_W-1:0];
    if (wr_rm)    fp_after_wr[RM_LO +: RM_W] = wr_data[RM_W-1:0];
    fp_d = fp_after_wr;
    fp_d[FLG_NX] = fp_after_wr[FLG_NX] | set_nx;
    fp_d[FLG_DZ] = fp_after_wr[FLG_DZ] | set_dz;
    fp_d[FLG_NV] = fp_after_wr[FLG_NV] | set_nv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fpctl_q <= '0;
    else        fpctl_q <= fp_d;
  end

  assert_flag_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_nx || set_dz || set_nv) |=>
      ((fpctl_q[FLG_NX] || !$past(set_nx)) && (fpctl_q[FLG_DZ] || !$past(set_dz))
       && (fpctl_q[FLG_NV] || !$past(set_nv))));

  assert_rm_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rm && !wr_ctl && !wr_flags && !any_flag_set) |=>
      (fpctl_q[RM_LO +: RM_W] == $past(wr_data[RM_W-1:0]))
      && (fpctl_q[FLG_W-1:0] == $past(fpctl_q[FLG_W-1:0])));

endmodule

// File: rtl/csr_gen_bank.sv
module csr_gen_bank
  import csr_alias_pkg::*;
#(
  parameter int GEN_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GEN_AW-1:0] idx,
  input  logic [XW-1:0]     wr_data,
  output logic [XW-1:0]     rd_data
);

  localparam int DEPTH = 1 << GEN_AW;

  logic [XW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= wr_data;
    end
  end

  assign rd_data = mem[idx];

  assert_bank_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $stable(idx)) |=> (idx != $past(idx)) || (rd_data == $past(wr_data)));

endmodule

// File: rtl/csr_alias_file.sv
module csr_alias_file
  import csr_alias_pkg::*;
#(
  parameter int GEN_AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   csr_addr,
  input  logic          csr_rd,
  input  logic          csr_wr,
  input  logic [63:0]   csr_wdata,
  output logic [63:0]   csr_rdata,
  input  logic          insn_tick,
  input  logic          flag_nx,
  input  logic          flag_dz,
  input  logic          flag_nv,
  input  logic          mret_go,
  output logic [63:0]   mret_pc
);

  csr_sel_e      sel;
  logic          wr_flags, wr_rmode, wr_fpctl, wr_sstat, wr_sien, wr_spend;
  logic          wr_mstat, wr_mdeleg, wr_mien, wr_mretpc, wr_mpend, wr_time, wr_gen;
  logic [XW-1:0] mstatus_q, mien_q, mpend_q, mdeleg_q, mretpc_q, time_q, time_d, gen_rd;
  logic [FPW-1:0] fpctl_q;
  logic          time_wrap;
  logic [XW-1:0] view_q;

  assign sel       = decode_addr(csr_addr);
  assign wr_flags  = csr_wr && (sel == SEL_FLAGS);
  assign wr_rmode  = csr_wr && (sel == SEL_RMODE);
  assign wr_fpctl  = csr_wr && (sel == SEL_FPCTL);
  assign wr_sstat  = csr_wr && (sel == SEL_SSTAT);
  assign wr_sien   = csr_wr && (sel == SEL_SIEN);
  assign wr_spend  = csr_wr && (sel == SEL_SPEND);
  assign wr_mstat  = csr_wr && (sel == SEL_MSTAT);
  assign wr_mdeleg = csr_wr && (sel == SEL_MDELEG);
  assign wr_mien   = csr_wr && (sel == SEL_MIEN);
  assign wr_mretpc = csr_wr && (sel == SEL_MRETPC);
  assign wr_mpend  = csr_wr && (sel == SEL_MPEND);
  assign wr_time   = csr_wr && (sel == SEL_TIME);
  assign wr_gen    = csr_wr && (sel == SEL_GEN);

  csr_status_unit u_status (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_mstat), .wr_view(wr_sstat),
    .wr_data(csr_wdata), .mret(mret_go), .status_q(mstatus_q)
  );

  csr_masked_reg #(.STORE_MASK('1), .VIEW_MASK(SUP_INT_MASK)) u_mien (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_mien), .wr_view(wr_sien),
    .wr_data(csr_wdata), .reg_q(mien_q)
  );

  csr_masked_reg #(.STORE_MASK('1), .VIEW_MASK(SUP_INT_MASK)) u_mpend (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_mpend), .wr_view(wr_spend),
    .wr_data(csr_wdata), .reg_q(mpend_q)
  );

  csr_masked_reg #(.STORE_MASK(DELEG_MASK), .VIEW_MASK('0)) u_mdeleg (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_mdeleg), .wr_view(1'b0),
    .wr_data(csr_wdata), .reg_q(mdeleg_q)
  );

  csr_masked_reg #(.STORE_MASK('1), .VIEW_MASK('0)) u_mretpc (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_mretpc), .wr_view(1'b0),
    .wr_data(csr_wdata), .reg_q(mretpc_q)
  );

  csr_fp_unit u_fp (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_fpctl), .wr_flags(wr_flags),
    .wr_rm(wr_rmode), .wr_data(csr_wdata), .set_nx(flag_nx), .set_dz(flag_dz),
    .set_nv(flag_nv), .fpctl_q(fpctl_q)
  );

  csr_gen_bank #(.GEN_AW(GEN_AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_gen), .idx(csr_addr[GEN_AW-1:0]),
    .wr_data(csr_wdata), .rd_data(gen_rd)
  );

  // Time counter: a port write lands first, the tick adds on top.
  always_comb begin
    time_d = wr_time ? csr_wdata : time_q;
    if (insn_tick) time_d = time_d + XW'(1);
  end

  assign time_wrap = insn_tick && !wr_time && (&time_q);

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  assert_time_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_tick && !wr_time) |=> time_q == $past(time_q) + XW'(1));

  assert_time_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    time_wrap |=> time_q == '0);

  // Read side: views mask their backing register.
  always_comb begin
    case (sel)
      SEL_FLAGS:  view_q = XW'(fpctl_q[FLG_W-1:0]);
      SEL_RMODE:  view_q = XW'(fpctl_q[RM_LO +: RM_W]);
      SEL_FPCTL:  view_q = XW'(fpctl_q);
      SEL_SSTAT:  view_q = mstatus_q & SUP_STATUS_MASK;
      SEL_SIEN:   view_q = mien_q & SUP_INT_MASK;
      SEL_SPEND:  view_q = mpend_q & SUP_INT_MASK;
      SEL_MSTAT:  view_q = mstatus_q;
      SEL_MDELEG: view_q = mdeleg_q;
      SEL_MIEN:   view_q = mien_q;
      SEL_MRETPC: view_q = mretpc_q;
      SEL_MPEND:  view_q = mpend_q;
      SEL_TIME:   view_q = time_q;
      default:    view_q = gen_rd;
    endcase
  end

  assign csr_rdata = csr_rd ? view_q : '0;
  assign mret_pc   = mretpc_q;

  assert_rd_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |-> csr_rdata == '0);

  assert_retpc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mretpc |=> $stable(mret_pc));

endmodule

// File: tb/csr_alias_file_bench.sv
module csr_alias_file_bench;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] csr_addr;
  logic        csr_rd, csr_wr, insn_tick, flag_nx, flag_dz, flag_nv, mret_go;
  logic [63:0] csr_wdata, csr_rdata, mret_pc;

  int checks = 0;
  int errors = 0;

  // Behavioural model state
  logic [63:0] m_st, m_ie, m_ip, m_dg, m_pc, m_tm;
  logic [7:0]  m_fp;
  logic [63:0] m_gen [logic [11:0]];

  localparam logic [63:0] K_SMASK = 64'h8000_0003_000D_E162;
  localparam logic [63:0] K_IMASK = 64'h222;

  logic [11:0] pool [15] = '{12'h001, 12'h002, 12'h003, 12'h100, 12'h104,
                             12'h144, 12'h300, 12'h303, 12'h304, 12'h344,
                             12'h341, 12'hC01, 12'h340, 12'h7C0, 12'hB03};

  csr_alias_file u_csr_alias_file (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .insn_tick(insn_tick), .flag_nx(flag_nx), .flag_dz(flag_dz),
    .flag_nv(flag_nv), .mret_go(mret_go), .mret_pc(mret_pc)
  );

  always #(CLK_NS/2) clk = ~clk;

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [63:0] m_read(input logic [11:0] a);
    if (a == 12'h001) return {59'd0, m_fp[4:0]};
    if (a == 12'h002) return {61'd0, m_fp[7:5]};
    if (a == 12'h003) return {56'd0, m_fp};
    if (a == 12'h100) return m_st & K_SMASK;
    if (a == 12'h104) return m_ie & K_IMASK;
    if (a == 12'h144) return m_ip & K_IMASK;
    if (a == 12'h300) return m_st;
    if (a == 12'h303) return m_dg;
    if (a == 12'h304) return m_ie;
    if (a == 12'h344) return m_ip;
    if (a == 12'h341) return m_pc;
    if (a == 12'hC01) return m_tm;
    return m_gen.exists(a) ? m_gen[a] : 64'd0;
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h001, 12'h002, 12'h003: return "R6";
      12'h100, 12'h300:          return "R3";
      12'h104, 12'h144, 12'h304, 12'h344: return "R4";
      12'h303:                   return "R5";
      12'h341:                   return "R9";
      12'hC01:                   return "R8";
      default:                   return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic m_update(input logic [11:0] a, input logic wr, input logic [63:0] d,
                          input logic tk, input logic nx, input logic dz,
                          input logic nv, input logic mr);
    if (wr) begin
      case (a)
        12'h001: m_fp[4:0] = d[4:0];
        12'h002: m_fp[7:5] = d[2:0];
        12'h003: m_fp      = d[7:0];
        12'h100: m_st = (m_st & ~K_SMASK) | (d & K_SMASK);
        12'h104: m_ie = (m_ie & ~K_IMASK) | (d & K_IMASK);
        12'h144: m_ip = (m_ip & ~K_IMASK) | (d & K_IMASK);
        12'h300: m_st = d;
        12'h303: m_dg = d & 64'h666;
        12'h304: m_ie = d;
        12'h344: m_ip = d;
        12'h341: m_pc = d;
        12'hC01: m_tm = d;
        default: m_gen[a] = d;
      endcase
    end
    if (nx) m_fp = m_fp | 8'h01;
    if (dz) m_fp = m_fp | 8'h08;
    if (nv) m_fp = m_fp | 8'h10;
    if (tk) m_tm = m_tm + 64'd1;
    if (mr) begin
      logic pie;
      pie = m_st[7];
      m_st[3] = pie;
      m_st[7] = 1'b1;
      m_st[17] = 1'b0;
    end
  endtask

  // One cycle: drive, compare combinational outputs, advance the model at the edge.
  task automatic step(input logic [11:0] a, input logic rd, input logic wr,
                      input logic [63:0] d, input logic tk, input logic nx,
                      input logic dz, input logic nv, input logic mr, input string req);
    csr_addr = a; csr_rd = rd; csr_wr = wr; csr_wdata = d; insn_tick = tk;
    flag_nx = nx; flag_dz = dz; flag_nv = nv; mret_go = mr;
    #1;
    check(req, csr_rdata, rd ? m_read(a) : 64'd0, "rdata");
    check("R9", mret_pc, m_pc, "mret_pc");
    @(posedge clk);
    m_update(a, wr, d, tk, nx, dz, nv, mr);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [63:0] d, input string req);
    step(a, 1'b1, 1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic rd_reg(input logic [11:0] a, input string req);
    step(a, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    m_st = '0; m_ie = '0; m_ip = '0; m_dg = '0; m_pc = '0; m_tm = '0; m_fp = '0;
    rst_n = 1'b0; csr_addr = '0; csr_rd = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
    insn_tick = 1'b0; flag_nx = 1'b0; flag_dz = 1'b0; flag_nv = 1'b0; mret_go = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int i = 0; i < 15; i++) rd_reg(pool[i], "R1");

    // R3: supervisor status window
    wr_reg(12'h300, '1, "R3");
    rd_reg(12'h100, "R3");
    wr_reg(12'h100, 64'd0, "R3");
    rd_reg(12'h300, "R3");

    // R4: interrupt views
    wr_reg(12'h304, 64'h0F0F, "R4");
    wr_reg(12'h104, '1, "R4");
    rd_reg(12'h304, "R4");
    wr_reg(12'h344, '1, "R4");
    wr_reg(12'h144, 64'd0, "R4");
    rd_reg(12'h344, "R4");
    rd_reg(12'h144, "R4");

    // R5: delegation mask
    wr_reg(12'h303, '1, "R5");
    rd_reg(12'h303, "R5");

    // R6: floating-point windows
    wr_reg(12'h003, 64'hFFFF_FFFF_FFFF_FF5A, "R6");
    rd_reg(12'h003, "R6");
    wr_reg(12'h002, 64'hFFFF_FFF9, "R6");
    rd_reg(12'h003, "R6");
    rd_reg(12'h002, "R6");
    wr_reg(12'h001, 64'h0, "R6");
    rd_reg(12'h003, "R6");

    // R7: flag raise alone and on top of a same-cycle write
    step(12'h001, 1'b1, 1'b0, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    rd_reg(12'h001, "R7");
    step(12'h001, 1'b1, 1'b1, 64'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    rd_reg(12'h001, "R7");
    step(12'h003, 1'b1, 1'b1, 64'hE0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    rd_reg(12'h003, "R7");

    // R8: time counting, wrap, write plus tick
    for (int i = 0; i < 4; i++)
      step(12'hC01, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    wr_reg(12'hC01, '1, "R8");
    step(12'hC01, 1'b1, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    rd_reg(12'hC01, "R8");
    step(12'hC01, 1'b1, 1'b1, 64'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    rd_reg(12'hC01, "R8");

    // R9: machine return
    wr_reg(12'h341, 64'h8000_1234, "R9");
    wr_reg(12'h300, 64'h0002_0080, "R9");
    step(12'h300, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    rd_reg(12'h300, "R9");
    step(12'h300, 1'b1, 1'b1, 64'h0002_0008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    rd_reg(12'h300, "R9");
    step(12'h100, 1'b1, 1'b1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    rd_reg(12'h300, "R9");

    // R10: generic bank and isolation from named registers
    wr_reg(12'h340, 64'hDEAD_BEEF_0000_0001, "R10");
    wr_reg(12'h7C0, 64'h1111_2222_3333_4444, "R10");
    rd_reg(12'h340, "R10");
    rd_reg(12'h7C0, "R10");
    rd_reg(12'h341, "R10");

    // R2: read strobe low shows zero
    step(12'h340, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    step(12'h300, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

    // Mixed random stream: overlapping writes, flags, ticks and returns
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      a = pool[$urandom_range(0, 14)];
      step(a, ($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1,
           {$urandom, $urandom}, $urandom_range(0, 1) == 1,
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0, req_of(a));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule